// File: doc/BRIEF.md
# Serial Register Port with Shadowed Gain

This block is a serial slave that gives a host read and write access to a bank of 8-bit configuration registers. A transfer runs while the active-low select `cs_n` is held low. The host first shifts in an instruction byte, then one to four data bytes, all most significant bit first, on the external serial clock. Input bits are taken on the rising clock edge. Read data is launched on the falling edge, so it has settled before the host samples it on the next rising edge.

A mode bit in the control register chooses one of two pin arrangements. In three-pin mode, read data goes back on the shared data line, and the block drives that line only while it is sending a read byte. In four-pin mode, read data goes out on `sdo` and the shared line is always an input. The pad tristate sits outside the block, so the shared line appears as a separate input, output and output-enable.

Two gain bytes are double-buffered. A write to either one lands in a pending copy. Both pending copies move into the live gain word together when the offset low byte is written. The bank also holds a 16-bit fixed sample word. A control bit can make this word replace the sample that passes through the block.

Top module: `ser_reg_port`

## Requirements
- R1: After reset every register reads 0x00, `gain_word` and `offs_word` are zero, `sdio_oe` and `sdo` are low, and `data_out` follows `data_in`.
- R2: The instruction byte is bit 7 = direction (1 read, 0 write), bits 6:5 = count N, bits 4:0 = start address. Every byte is shifted most significant bit first and sampled on the rising edge of `sclk`.
- R3: A one-byte write stores the byte at the addressed register, and a later read returns it. Other registers are not changed.
- R4: A transfer moves N+1 bytes to or from consecutive addresses. The address wraps from 0x1F to 0x00. Bytes sent after the count is used up are ignored.
- R5: Read data is launched on the falling edge of `sclk`. Bit 7 of the first byte appears on the falling edge after the last instruction bit, and the following bits and bytes come one per clock.
- R6: In three-pin mode (control register 0x00 bit 7 = 0), `sdio_oe` is high only during the data phase of a read while `cs_n` is low, and `sdo` stays low.
- R7: In four-pin mode (control register 0x00 bit 7 = 1), read data comes out on `sdo` and `sdio_oe` stays low.
- R8: Writes to gain bytes 0x03 (low) and 0x04 (high) are held pending. `gain_word` and the read-back value of these bytes change only when register 0x05 is written, and then both bytes take effect together. `offs_word` is {0x06, 0x05}.
- R9: Registers 0x01 (low) and 0x02 (high) form the fixed word. While control register 0x00 bit 6 = 1, `data_out` equals the fixed word. Otherwise `data_out` equals `data_in`.
- R10: Raising `cs_n` partway through a byte aborts the transfer and throws away the partial byte without writing it. The next transfer starts again with an instruction byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the host |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low transfer select |
| sdio_i | input | 1 | Shared data line, input side |
| sdio_o | output | 1 | Shared data line, output value |
| sdio_oe | output | 1 | Shared data line, drive enable (three-pin reads) |
| sdo | output | 1 | Dedicated read data output (four-pin mode) |
| data_in | input | 16 | Sample entering the block |
| data_out | output | 16 | Sample or fixed word |
| gain_word | output | 16 | Committed gain {0x04, 0x03} |
| offs_word | output | 16 | Offset word {0x06, 0x05} |

## Verification
Reads and writes are exercised with single bytes, four-byte bursts that cross the 0x1F-to-0x00 wrap, and a write that sends more bytes than its count. This separates correct address stepping and count handling from errors off by one byte. Alternating and edge-bit data (0x80, 0x01, 0xFF, 0x00, 0x5A) exposes bit-order and launch-edge mistakes, and the same data is read in both pin modes to show that the right output is selected. Gain writes made alone, then the trigger write, and a burst that carries gain and trigger in one transfer show whether the commit happens at the right moment. Transfers cut short inside the instruction and inside a data byte show that partial bytes are discarded.

// File: rtl/ser_reg_pkg.sv
`timescale 1ns/1ps
package ser_reg_pkg;
  typedef enum logic [1:0] {PH_INSTR, PH_WRITE, PH_READ, PH_DONE} phase_t;

  localparam int ADDR_CTRL    = 0;
  localparam int ADDR_FIX_LO  = 1;
  localparam int ADDR_FIX_HI  = 2;
  localparam int ADDR_GAIN_LO = 3;
  localparam int ADDR_GAIN_HI = 4;
  localparam int ADDR_TRIG    = 5;
  localparam int ADDR_OFFS_HI = 6;

  localparam int BIT_FOURPIN  = 7;
  localparam int BIT_FIXSEL   = 6;
endpackage

// File: rtl/ser_reg_shift.sv
`timescale 1ns/1ps
module ser_reg_shift
  import ser_reg_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int CW = 2
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sdi,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] cur_addr,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          rd_phase,
  output logic          launch_en,
  output logic          launch_bit
);
  localparam int BW = $clog2(DW);

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  phase_t        phase;
  logic [BW-1:0] bit_cnt;
  logic [DW-2:0] shreg;
  logic [CW-1:0] left;
  logic [AW-1:0] addr;
  logic [DW-1:0] full_byte;
  logic          byte_done;

  assign full_byte = {shreg, sdi};
  assign byte_done = !cs_n && (bit_cnt == BW'(DW-1));
  assign wr_en     = byte_done && (phase == PH_WRITE);
  assign wr_data   = full_byte;
  assign cur_addr  = addr;
  assign rd_phase  = (phase == PH_READ);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_INSTR;
      bit_cnt <= '0;
      shreg   <= '0;
      left    <= '0;
      addr    <= '0;
    end else if (cs_n) begin
      phase   <= PH_INSTR;
      bit_cnt <= '0;
      shreg   <= '0;
    end else begin
      bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
      shreg   <= full_byte[DW-2:0];
      if (byte_done) begin
        case (phase)
          PH_INSTR: begin
            addr  <= full_byte[AW-1:0];
            left  <= full_byte[AW +: CW];
            phase <= full_byte[DW-1] ? PH_READ : PH_WRITE;
          end
          PH_WRITE, PH_READ: begin
            addr <= step_addr(addr);
            if (left == '0) phase <= PH_DONE;
            else            left  <= left - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      launch_en  <= 1'b0;
      launch_bit <= 1'b0;
    end else begin
      launch_en  <= !cs_n && (phase == PH_READ);
      launch_bit <= rd_data[BW'(DW-1) - bit_cnt];
    end
  end

  // R10
  idle_reset_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |=> (phase == PH_INSTR && bit_cnt == '0));

  // R4
  addr_step_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    wr_en |=> (addr == step_addr($past(addr))));
endmodule

// File: rtl/ser_reg_bank.sv
`timescale 1ns/1ps
module ser_reg_bank
  import ser_reg_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          four_pin,
  output logic          fix_en,
  output logic [2*DW-1:0] fix_word,
  output logic [2*DW-1:0] gain_word,
  output logic [2*DW-1:0] offs_word
);
  localparam int NREG = 1 << AW;

  logic [NREG-1:0][DW-1:0] regs;
  logic commit;

  assign commit = wr_en && (addr == AW'(ADDR_TRIG));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam bit SHADOWED = (i == ADDR_GAIN_LO) || (i == ADDR_GAIN_HI);
    logic          hit;
    logic [DW-1:0] q;
    assign hit     = wr_en && (addr == AW'(i));
    assign regs[i] = q;
    if (SHADOWED) begin : g_sh
      logic [DW-1:0] pend;
      always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
          pend <= '0;
          q    <= '0;
        end else begin
          if (hit)    pend <= wr_data;
          if (commit) q    <= pend;
        end
      end
    end else begin : g_pl
      always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wr_data;
      end
    end
  end

  assign rd_data   = regs[addr];
  assign four_pin  = regs[ADDR_CTRL][BIT_FOURPIN];
  assign fix_en    = regs[ADDR_CTRL][BIT_FIXSEL];
  assign fix_word  = {regs[ADDR_FIX_HI], regs[ADDR_FIX_LO]};
  assign gain_word = {regs[ADDR_GAIN_HI], regs[ADDR_GAIN_LO]};
  assign offs_word = {regs[ADDR_OFFS_HI], regs[ADDR_TRIG]};

  // R8
  gain_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !commit |=> $stable(gain_word));

  // R3
  write_land_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (wr_en && addr == AW'(ADDR_FIX_LO)) |=> (fix_word[DW-1:0] == $past(wr_data)));
endmodule

// File: rtl/ser_reg_port.sv
`timescale 1ns/1ps
module ser_reg_port #(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int CW = 2
) (
  input  logic            sclk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            sdio_i,
  output logic            sdio_o,
  output logic            sdio_oe,
  output logic            sdo,
  input  logic [2*DW-1:0] data_in,
  output logic [2*DW-1:0] data_out,
  output logic [2*DW-1:0] gain_word,
  output logic [2*DW-1:0] offs_word
);
  localparam int WW = 2 * DW;

  function automatic logic [WW-1:0] pick_word(input logic sel,
                                              input logic [WW-1:0] fixed,
                                              input logic [WW-1:0] live);
    return sel ? fixed : live;
  endfunction

  logic [AW-1:0] cur_addr;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          rd_phase;
  logic          launch_en;
  logic          launch_bit;
  logic          four_pin;
  logic          fix_en;
  logic [WW-1:0] fix_word;

  ser_reg_shift #(.AW(AW), .DW(DW), .CW(CW)) u_shift (
    .sclk       (sclk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sdi        (sdio_i),
    .rd_data    (rd_data),
    .cur_addr   (cur_addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_phase   (rd_phase),
    .launch_en  (launch_en),
    .launch_bit (launch_bit)
  );

  ser_reg_bank #(.AW(AW), .DW(DW)) u_bank (
    .sclk      (sclk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (cur_addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .four_pin  (four_pin),
    .fix_en    (fix_en),
    .fix_word  (fix_word),
    .gain_word (gain_word),
    .offs_word (offs_word)
  );

  assign sdio_o   = launch_bit;
  assign sdio_oe  = launch_en && !four_pin && !cs_n;
  assign sdo      = (launch_en && four_pin && !cs_n) ? launch_bit : 1'b0;
  assign data_out = pick_word(fix_en, fix_word, data_in);

  // R6
  oe_phase_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    sdio_oe |-> rd_phase);
endmodule

// File: tb/sim_ser_reg_port.sv
`timescale 1ns/1ps
module sim_ser_reg_port;
  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdio_i = 1'b0;
  logic [15:0] data_in = 16'h0000;
  logic        sdio_o, sdio_oe, sdo;
  logic [15:0] data_out, gain_word, offs_word;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #5 sclk = ~sclk;

  ser_reg_port u0 (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo),
    .data_in(data_in), .data_out(data_out),
    .gain_word(gain_word), .offs_word(offs_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    @(negedge sclk); #1;
    cs_n = 1'b0;
    sdio_i = b;
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic end_xfer();
    @(negedge sclk); #1;
    cs_n = 1'b1;
    sdio_i = 1'b0;
    @(negedge sclk); #2;
  endtask

  // bytes right-aligned, first byte most significant
  task automatic wr_bytes(input logic [4:0] a, input int cnt, input logic [31:0] d);
    put_byte({1'b0, 2'(cnt - 1), a});
    for (int k = 0; k < cnt; k++) put_byte(d[8*(cnt-1-k) +: 8]);
    end_xfer();
  endtask

  task automatic rd_bytes(input logic [4:0] a, input int cnt, input bit four,
                          output logic [31:0] q);
    q = '0;
    put_byte({1'b1, 2'(cnt - 1), a});
    for (int k = 0; k < cnt; k++) begin
      for (int i = 0; i < 8; i++) begin
        @(negedge sclk); #2;
        if (four) begin
          q = {q[30:0], sdo};
          if (sdio_oe !== 1'b0) chk("R7 sdio_oe low in four-pin read", 32'(sdio_oe), 0);
        end else begin
          q = {q[30:0], sdio_o};
          if (sdio_oe !== 1'b1) chk("R6 sdio_oe high in read data", 32'(sdio_oe), 1);
          if (sdo !== 1'b0) chk("R6 sdo low in three-pin", 32'(sdo), 0);
        end
      end
    end
    end_xfer();
    chk("R6 sdio_oe released after read", 32'(sdio_oe), 0);
  endtask

  task automatic t_reset();
    logic [31:0] q;
    data_in = 16'h1357; #1;
    chk("R1 sdio_oe reset", 32'(sdio_oe), 0);
    chk("R1 sdo reset", 32'(sdo), 0);
    chk("R1 gain_word reset", 32'(gain_word), 0);
    chk("R1 offs_word reset", 32'(offs_word), 0);
    chk("R1 data_out passes data_in", 32'(data_out), 32'h1357);
    for (int b = 0; b < 32; b += 4) begin
      rd_bytes(5'(b), 4, 1'b0, q);
      chk("R1 registers read 0x00", q, 0);
    end
  endtask

  task automatic t_single();
    logic [31:0] q;
    wr_bytes(5'h10, 1, 32'h5A);
    chk("R2 write keeps sdio_oe low", 32'(sdio_oe), 0);
    wr_bytes(5'h11, 1, 32'hA5);
    rd_bytes(5'h10, 1, 1'b0, q);
    chk("R3 single read 0x10", q, 32'h5A);
    rd_bytes(5'h11, 1, 1'b0, q);
    chk("R3 single read 0x11", q, 32'hA5);
    rd_bytes(5'h0F, 1, 1'b0, q);
    chk("R3 neighbour untouched", q, 0);
    rd_bytes(5'h10, 2, 1'b0, q);
    chk("R5 two-byte read order", q, 32'h5AA5);
  endtask

  task automatic t_burst();
    logic [31:0] q;
    wr_bytes(5'h1E, 4, 32'h11220033);
    rd_bytes(5'h1E, 4, 1'b0, q);
    chk("R4 wrapped burst", q, 32'h11220033);
    put_byte({1'b0, 2'd0, 5'h08});
    put_byte(8'h77);
    put_byte(8'h88);
    end_xfer();
    rd_bytes(5'h08, 2, 1'b0, q);
    chk("R4 extra byte ignored", q, 32'h7700);
  endtask

  task automatic t_pattern();
    logic [31:0] q;
    wr_bytes(5'h12, 4, 32'h8001FF00);
    rd_bytes(5'h12, 4, 1'b0, q);
    chk("R5 edge-bit pattern", q, 32'h8001FF00);
    rd_bytes(5'h14, 1, 1'b0, q);
    chk("R5 single 0xFF", q, 32'hFF);
    rd_bytes(5'h13, 1, 1'b0, q);
    chk("R5 single 0x01", q, 32'h01);
  endtask

  task automatic t_abort();
    logic [31:0] q;
    wr_bytes(5'h0A, 1, 32'h3C);
    put_byte({1'b0, 2'd0, 5'h0A});
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    end_xfer();
    rd_bytes(5'h0A, 1, 1'b0, q);
    chk("R10 partial data byte dropped", q, 32'h3C);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    end_xfer();
    wr_bytes(5'h0B, 1, 32'h44);
    rd_bytes(5'h0B, 1, 1'b0, q);
    chk("R10 fresh instruction after abort", q, 32'h44);
    rd_bytes(5'h0A, 1, 1'b0, q);
    chk("R10 earlier value intact", q, 32'h3C);
  endtask

  task automatic t_shadow();
    logic [31:0] q;
    wr_bytes(5'h03, 2, 32'hABCD);
    chk("R8 gain held before trigger", 32'(gain_word), 0);
    rd_bytes(5'h03, 2, 1'b0, q);
    chk("R8 gain readback before trigger", q, 0);
    wr_bytes(5'h05, 1, 32'h9E);
    chk("R8 gain committed", 32'(gain_word), 32'hCDAB);
    chk("R8 offset low", 32'(offs_word), 32'h009E);
    rd_bytes(5'h03, 2, 1'b0, q);
    chk("R8 gain readback after trigger", q, 32'hABCD);
    wr_bytes(5'h06, 1, 32'h12);
    chk("R8 offset word", 32'(offs_word), 32'h129E);
    chk("R8 gain unchanged by 0x06", 32'(gain_word), 32'hCDAB);
    wr_bytes(5'h03, 1, 32'h01);
    chk("R8 single gain byte held", 32'(gain_word), 32'hCDAB);
    wr_bytes(5'h05, 1, 32'h9E);
    chk("R8 partial update committed", 32'(gain_word), 32'hCD01);
    wr_bytes(5'h03, 3, 32'h556677);
    chk("R8 burst with trigger", 32'(gain_word), 32'h6655);
    chk("R8 burst offset low", 32'(offs_word), 32'h1277);
  endtask

  task automatic t_fixed();
    wr_bytes(5'h01, 2, 32'h3412);
    data_in = 16'hBEEF; #1;
    chk("R9 select off", 32'(data_out), 32'hBEEF);
    wr_bytes(5'h00, 1, 32'h40);
    chk("R9 fixed word selected", 32'(data_out), 32'h1234);
    data_in = 16'h0F0F; #1;
    chk("R9 input ignored while fixed", 32'(data_out), 32'h1234);
    wr_bytes(5'h00, 1, 32'h00);
    chk("R9 select cleared", 32'(data_out), 32'h0F0F);
  endtask

  task automatic t_four();
    logic [31:0] q;
    wr_bytes(5'h00, 1, 32'h80);
    chk("R7 sdo idle low", 32'(sdo), 0);
    rd_bytes(5'h10, 1, 1'b1, q);
    chk("R7 four-pin read", q, 32'h5A);
    rd_bytes(5'h12, 4, 1'b1, q);
    chk("R7 four-pin burst", q, 32'h8001FF00);
    wr_bytes(5'h00, 1, 32'h00);
    rd_bytes(5'h10, 1, 1'b0, q);
    chk("R6 back to three-pin", q, 32'h5A);
  endtask

  initial begin
    repeat (3) @(negedge sclk);
    rst_n = 1'b1;
    @(negedge sclk); #2;
    t_reset();
    t_single();
    t_burst();
    t_pattern();
    t_abort();
    t_shadow();
    t_fixed();
    t_four();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule